// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a small two-wire serial memory with 128 bytes of storage. It oversamples the clock line (SCL) and the data line (SDA) with the system clock and recognises start and stop conditions. It shifts in 8-bit words and acknowledges them. It returns stored bytes to the bus master. It never drives SDA high. It only asks the pad to pull the line low, through a single output-enable.

A transaction opens with one command byte. That byte carries a 7-bit word address and a read/write flag, with no device-select field. On a write, up to four data bytes collect in a page buffer. The stop that closes the transaction then starts a timed internal write cycle. For that whole cycle the slave stays silent and ignores the bus. Only when the cycle ends does the page reach the array.

A read returns bytes from the slave's own address counter. To read a chosen location, the master first sends a write command that carries only the address, then a stop or a fresh start, and then a read command.

Top module: `eep_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high), seen outside the internal write cycle, begins a new command byte from any state. Page data not yet written is discarded.
- R2: The command byte arrives MSB first. Bits 7..1 are the word address and bit 0 is the direction: 0 means write, 1 means read. The slave acknowledges it by holding SDA low through the ninth SCL pulse.
- R3: After a write command, each data byte is acknowledged. After the stop and the write cycle, a single data byte is found at the commanded address.
- R4: In a page write, each later byte goes to the next address. Only address bits 1..0 advance, wrapping within the 4-byte page, and bits 6..2 stay fixed.
- R5: A stop that follows at least one data byte starts a write cycle of WR_CYCLES system clocks. During that cycle SDA is released, and every start, command and data byte is ignored: no acknowledge is given and the memory is unchanged.
- R6: A stop that follows a write command with no data byte starts no write cycle. The next command is acknowledged at once, and the address counter keeps the commanded address.
- R7: A read command makes the slave send bytes MSB first, starting at its address counter. The counter advances after each byte and wraps from 127 to 0.
- R8: A master acknowledge (SDA low on the ninth clock) makes the slave send the next byte. A master no-acknowledge makes it release SDA and wait for a stop or start.
- R9: The slave's pull-low enable changes only while SCL is low.
- R10: After an interrupted read, the master can recover the slave. It clocks SCL with SDA released until it sees SDA high while SCL is high, then issues a start. The next command is then handled normally.
- R11: While reset is active, and after it is released, SDA is released and the slave waits for a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
A wrong bit counter or shift state shows up at the ninth SCL pulse of the next word. The acknowledge is then missing, misplaced, or the read byte arrives rotated. An address counter fault shows only when data is read back, after a full write cycle: a page-wrap or counter-wrap error puts the stored bytes in the wrong order. A write-cycle state that ends early or late shows at the first command sent after the stop, which is acknowledged when it should not be or refused when it should be. A stuck pull-low enable holds SDA low and blocks the next start or stop.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WCYCLE
  } eep_state_e;

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_meta, scl_sync, scl_prev;
  logic sda_meta, sda_sync, sda_prev;

  // two-stage synchronisers plus one history stage; idle bus is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_meta <= 1'b1;
      scl_sync <= 1'b1;
      scl_prev <= 1'b1;
      sda_meta <= 1'b1;
      sda_sync <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_meta <= scl_i;
      scl_sync <= scl_meta;
      scl_prev <= scl_sync;
      sda_meta <= sda_i;
      sda_sync <= sda_meta;
      sda_prev <= sda_sync;
    end
  end

  assign scl_lvl   = scl_sync;
  assign sda_lvl   = sda_sync;
  assign scl_rise  = scl_sync & ~scl_prev;
  assign scl_fall  = ~scl_sync & scl_prev;
  assign start_det = scl_sync & scl_prev & sda_prev & ~sda_sync;
  assign stop_det  = scl_sync & scl_prev & ~sda_prev & sda_sync;

endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     ld_en,
  input  logic [PAGE_W-1:0]        ld_idx,
  input  logic [DATA_W-1:0]        ld_data,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] page_base,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     pending
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] buf_q [PAGE_N];
  logic [PAGE_N-1:0] vld_q;

  // page staging buffer: data has a clock enable only, valid bits are reset
  always_ff @(posedge clk) begin
    if (ld_en) buf_q[ld_idx] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clr || commit) begin
      vld_q <= '0;
    end else if (ld_en) begin
      vld_q[ld_idx] <= 1'b1;
    end
  end

  // whole page lands in the array in the single commit cycle
  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_N; i++) begin
      if (commit && vld_q[i]) mem_q[{page_base, PAGE_W'(i)}] <= buf_q[i];
    end
  end

  assign rd_data = mem_q[rd_addr];
  assign pending = |vld_q;

endmodule

// File: rtl/eep_slave.sv
module eep_slave import eep_pkg::*; #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 2,
  parameter int WR_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  eep_state_e          state_q, state_d;
  logic [3:0]          bit_q, bit_d;
  logic [DATA_W-1:0]   shf_q, shf_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                oe_q, oe_d;
  logic [CNT_W-1:0]    wcnt_q, wcnt_d;

  logic                ld_en, clr, commit, page_pending;
  logic [DATA_W-1:0]   rd_data;
  logic [ADDR_W-1:0]   addr_page_inc;

  eep_line_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .ld_en     (ld_en),
    .ld_idx    (addr_q[PAGE_W-1:0]),
    .ld_data   (shf_q),
    .commit    (commit),
    .page_base (addr_q[ADDR_W-1:PAGE_W]),
    .rd_addr   (addr_q),
    .rd_data   (rd_data),
    .pending   (page_pending)
  );

  // only the in-page bits advance during a write
  assign addr_page_inc = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    shf_d   = shf_q;
    addr_d  = addr_q;
    oe_d    = oe_q;
    wcnt_d  = wcnt_q;
    ld_en   = 1'b0;
    clr     = 1'b0;
    commit  = 1'b0;

    if (state_q == ST_WCYCLE) begin
      // bus is ignored until the timed cycle completes
      if (wcnt_q == CNT_W'(WR_CYCLES - 1)) begin
        commit  = 1'b1;
        wcnt_d  = '0;
        state_d = ST_IDLE;
      end else begin
        wcnt_d = wcnt_q + CNT_W'(1);
      end
    end else if (start_det) begin
      state_d = ST_CMD;
      bit_d   = '0;
      oe_d    = 1'b0;
      clr     = 1'b1;
    end else if (stop_det) begin
      oe_d    = 1'b0;
      wcnt_d  = '0;
      state_d = page_pending ? ST_WCYCLE : ST_IDLE;
    end else begin
      case (state_q)
        ST_CMD, ST_WDATA: begin
          if (scl_rise && bit_q < 4'd8) begin
            shf_d = {shf_q[DATA_W-2:0], sda_lvl};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            oe_d  = 1'b1;
            bit_d = '0;
            if (state_q == ST_CMD) begin
              state_d = ST_CMD_ACK;
              if (!shf_q[0]) addr_d = shf_q[ADDR_W:1];
            end else begin
              state_d = ST_WDATA_ACK;
              ld_en   = 1'b1;
              addr_d  = addr_page_inc;
            end
          end
        end
        ST_CMD_ACK: begin
          if (scl_fall) begin
            if (shf_q[0]) begin
              shf_d   = rd_data;
              oe_d    = ~rd_data[DATA_W-1];
              addr_d  = addr_q + ADDR_W'(1);
              bit_d   = '0;
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WDATA;
            end
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              oe_d    = 1'b0;
              bit_d   = '0;
              state_d = ST_RACK;
            end else begin
              shf_d = {shf_q[DATA_W-2:0], 1'b0};
              oe_d  = ~shf_q[DATA_W-2];
              bit_d = bit_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            bit_d = {3'b000, sda_lvl};
          end else if (scl_fall) begin
            if (!bit_q[0]) begin
              shf_d   = rd_data;
              oe_d    = ~rd_data[DATA_W-1];
              addr_d  = addr_q + ADDR_W'(1);
              bit_d   = '0;
              state_d = ST_RDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shf_q   <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      shf_q   <= shf_d;
      addr_q  <= addr_d;
      oe_q    <= oe_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign sda_oe = oe_q;

endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk import eep_pkg::*; #(
  parameter int WR_CYCLES = 500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       start_det,
  input logic       stop_det,
  input logic       pending,
  input eep_state_e state,
  input logic       sda_oe
);

  localparam int RUN_W = $clog2(WR_CYCLES + 2) + 1;

  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (state == ST_WCYCLE) busy_run <= busy_run + RUN_W'(1);
    else busy_run <= '0;
  end

  // R1: a start outside the write cycle reopens command reception
  p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && state != ST_WCYCLE) |=> (state == ST_CMD));

  // R5: silent bus during the write cycle
  p_quiet_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WCYCLE) |-> !sda_oe);

  // R5: write cycle never outlasts its length
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= RUN_W'(WR_CYCLES));

  // R6: an empty stop does not start a write cycle
  p_empty_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && state != ST_WCYCLE && !pending) |=> (state != ST_WCYCLE));

  // R8: the master acknowledge slot is left free
  p_mack_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK) |-> !sda_oe);

  // R9: pull-low enable moves only while SCL is low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));

endmodule

bind eep_slave eep_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_eep_slave_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .start_det (start_det),
  .stop_det  (stop_det),
  .pending   (page_pending),
  .state     (state_q),
  .sda_oe    (sda_oe)
);

// File: tb/test_eep_slave.sv
module test_eep_slave;

  localparam int WR = 500;
  localparam int PH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;
  int oe_bad = 0;
  int oe_moves = 0;
  logic prev_oe = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rx_byte;
  event       rx_ev;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  eep_slave #(.WR_CYCLES(WR)) i_eep_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // R9 observer: enable must only move while SCL is low at the pins
  always @(negedge clk) begin
    if (sda_oe !== prev_oe) begin
      oe_moves++;
      if (scl) oe_bad++;
    end
    prev_oe = sda_oe;
  end

  // scoreboard monitor: compare each received byte with the queue head
  initial begin
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected byte", rx_byte, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rx_byte == e, t, rx_byte, e);
      end
    end
  end

  task automatic hold();
    repeat (PH) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl = 1'b1;   hold();
    sda_m = 1'b0; hold();
    scl = 1'b0;   hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl = 1'b1;   hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic clock_bit(input logic v, output logic s);
    sda_m = v; hold();
    scl = 1'b1;
    repeat (PH/2) @(negedge clk);
    s = sda_line;
    repeat (PH/2) @(negedge clk);
    scl = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic mack);
    logic s;
    logic [7:0] b;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      b = {b[6:0], s};
    end
    clock_bit(!mack, s);
    rx_byte = b;
    -> rx_ev;
    @(negedge clk);
  endtask

  task automatic expect_byte(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic cmd(input logic [6:0] a, input logic rw, input logic exp_ack, input string req);
    logic ak;
    bus_start();
    send_byte({a, rw}, ak);
    check(ak == exp_ack, req, ak, exp_ack);
  endtask

  task automatic data(input logic [7:0] d, input logic exp_ack, input string req);
    logic ak;
    send_byte(d, ak);
    check(ak == exp_ack, req, ak, exp_ack);
  endtask

  task automatic wait_cycle();
    repeat (WR + 100) @(negedge clk);
  endtask

  task automatic read_at(input logic [6:0] a, input logic [7:0] v, input string req);
    cmd(a, 1'b0, 1'b1, req);
    bus_stop();
    cmd(7'h00, 1'b1, 1'b1, req);
    expect_byte(v, req);
    recv_byte(1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (PH * 150000 / PH) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic s;
    logic seen;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R11 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);

    // R2/R3: byte write, then write cycle polled (R5)
    cmd(7'h7F, 1'b0, 1'b1, "R2 command ack");
    data(8'hA5, 1'b1, "R3 data ack");
    bus_stop();
    cmd(7'h7F, 1'b0, 1'b0, "R5 no ack while busy");
    bus_stop();
    wait_cycle();
    cmd(7'h00, 1'b0, 1'b1, "R5 ack after cycle");
    data(8'h3C, 1'b1, "R3 data ack");
    bus_stop();
    wait_cycle();

    // R6 empty stop sets the counter; R7 wrap 127 -> 0; R8 continue/stop
    cmd(7'h7F, 1'b0, 1'b1, "R6 address set");
    bus_stop();
    cmd(7'h00, 1'b1, 1'b1, "R6 immediate ack");
    expect_byte(8'hA5, "R3 readback 7F");
    recv_byte(1'b1);
    expect_byte(8'h3C, "R7 counter wrap");
    recv_byte(1'b0);
    bus_stop();
    check(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);

    // R4: page write from 0x11 wraps inside page 0x10..0x13
    cmd(7'h11, 1'b0, 1'b1, "R4 command");
    data(8'h11, 1'b1, "R4 byte0");
    data(8'h22, 1'b1, "R4 byte1");
    data(8'h33, 1'b1, "R4 byte2");
    data(8'h44, 1'b1, "R4 byte3");
    bus_stop();
    wait_cycle();
    cmd(7'h10, 1'b0, 1'b1, "R4 address set");
    bus_stop();
    cmd(7'h00, 1'b1, 1'b1, "R4 read cmd");
    expect_byte(8'h44, "R4 wrapped byte at 10");
    recv_byte(1'b1);
    expect_byte(8'h11, "R4 byte at 11");
    recv_byte(1'b1);
    expect_byte(8'h22, "R4 byte at 12");
    recv_byte(1'b1);
    expect_byte(8'h33, "R8 byte at 13");
    recv_byte(1'b0);
    bus_stop();

    // R5: traffic during the write cycle changes nothing
    cmd(7'h20, 1'b0, 1'b1, "R5 command");
    data(8'h5A, 1'b1, "R5 data");
    bus_stop();
    cmd(7'h20, 1'b0, 1'b0, "R5 busy command ignored");
    data(8'hFF, 1'b0, "R5 busy data ignored");
    bus_stop();
    wait_cycle();
    read_at(7'h20, 8'h5A, "R5 memory unchanged");

    // R1: a repeated start discards pending page data
    cmd(7'h30, 1'b0, 1'b1, "R1 setup");
    data(8'h01, 1'b1, "R1 setup data");
    bus_stop();
    wait_cycle();
    cmd(7'h30, 1'b0, 1'b1, "R1 command");
    data(8'h77, 1'b1, "R1 data");
    cmd(7'h30, 1'b0, 1'b1, "R1 restart command");
    bus_stop();
    cmd(7'h00, 1'b1, 1'b1, "R1 no write cycle");
    expect_byte(8'h01, "R1 data discarded");
    recv_byte(1'b0);
    bus_stop();

    // R10: abort a read after 3 bits of 0x3C, then recover
    cmd(7'h00, 1'b0, 1'b1, "R10 address set");
    bus_stop();
    cmd(7'h00, 1'b1, 1'b1, "R10 read cmd");
    for (int i = 0; i < 3; i++) clock_bit(1'b1, s);
    seen = 1'b0;
    for (int k = 0; k < 9 && !seen; k++) begin
      sda_m = 1'b1; hold();
      scl = 1'b1; hold();
      seen = sda_line;
      if (!seen) begin
        scl = 1'b0; hold();
      end
    end
    check(seen == 1'b1, "R10 line seen high", seen, 1);
    sda_m = 1'b0; hold();
    scl = 1'b0; hold();
    begin
      logic ak;
      send_byte({7'h20, 1'b0}, ak);
      check(ak == 1'b1, "R10 command after recovery", ak, 1);
    end
    bus_stop();
    cmd(7'h00, 1'b1, 1'b1, "R10 read after recovery");
    expect_byte(8'h5A, "R10 readback");
    recv_byte(1'b0);
    bus_stop();

    check(oe_moves > 0 && oe_bad == 0, "R9 enable moved with SCL high", oe_bad, 0);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule